// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block steps a processor bus transfer through its timing states and drives the strobes that go with them. The states are T1, optional hold states, T2, optional peripheral states, optional wait states, T3 and T4. It runs from a single fast clock, which an internal toggle splits into two halves per processor cycle. The first half ends at a mid-state sampling edge. The second half ends at the state-change edge. The current half is shown on `cpu_clk_hi`.

A transfer begins when the address strobe is seen low at a state boundary while the block is idle or in T4. Three requests can lengthen a transfer, and they are served in a fixed order:
- a hold request, seen at the end of T1;
- a slow-peripheral request, seen on entry to T2;
- a continuous-wait request combined with a binary wait count, seen at a mid-state sampling point.

While any extension is pending, the ready output is low. The read and write strobes have a separate output enable, so that a board can float them.

Top module: `wait_state_ctl`

## Requirements
- R1: A transfer starts when `ads_n` is low at a state boundary while idle or in T4. With no extension it lasts exactly four processor cycles (T1, T2, T3, T4). `ads_n` low during T4 starts the next transfer at once. In reset, or while idle, every strobe and `tso_n` stay high and `rdy` stays high.
- R2: `xfer_wr` is captured at the boundary that starts T1 (0 = read, 1 = write). Only the matching strobe (`rd_n` or `wr_n`) is ever driven low, and the two are never low together.
- R3: `tso_n` falls at the start of T2 and rises at the start of T4. It stays low through every peripheral and wait state in between.
- R4: In a cycle with no peripheral request, the selected strobe is low from the start of T2 to the start of T4. `dbe_n` goes low at the start of T2 on writes and at the middle of T2 on reads. On both, `dbe_n` returns high at the middle of T4.
- R5: If `cwait_n` is low at the end of T1, a hold state follows. Another hold state follows at every boundary where `cwait_n` is still low. During hold, the strobes, `dbe_n` and `tso_n` are inactive and `rdy` is low.
- R6: `per_n` is looked at only on entry to T2. If it is low, five peripheral states PD0..PD4 follow T2. The selected strobe is then low only from PD0 through PD3 (plus any wait states placed after PD2), not in T2, PD4 or T3.
- R7: Hold is served before the peripheral check, which is made when hold ends. A peripheral cycle moves the wait sampling point from the middle of T2 to the middle of PD2. Wait states are placed between PD2 and PD3.
- R8: `wait_n` is an active-low binary count: N = bitwise NOT of `wait_n`, from 0 to 15. If `cwait_n` is high at the first sampling point, exactly N wait states are inserted.
- R9: Each time `cwait_n` is seen low at a sampling point, the count reloads from `wait_n` and one more wait state follows. When `cwait_n` is high in a wait state, the count decrements, and waits end once it is zero. Forcing `wait_n` to all ones during a continuous wait therefore cuts a longer count short after one more state.
- R10: `rdy` falls at the middle of T2 when an extension follows. It rises at the middle of the last extension state, which is the same state in which `cwait_n` is seen high with the count exhausted. It is high at the start of T4.
- R11: `strb_oe` is high exactly while `strb_hiz` is low. It changes with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two per processor cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, low marks a new transfer |
| xfer_wr | input | 1 | Direction, 0 read, 1 write |
| cwait_n | input | 1 | Hold / continuous-wait request, active low |
| per_n | input | 1 | Slow-peripheral request, active low |
| wait_n | input | 4 | Active-low binary wait count |
| strb_hiz | input | 1 | High floats the read/write strobes |
| cpu_clk_hi | output | 1 | High in the first half of each processor cycle |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strb_oe | output | 1 | Output enable for rd_n and wr_n |
| dbe_n | output | 1 | Data buffer enable, active low |
| tso_n | output | 1 | Timing-state output, low from T2 to T4 |
| rdy | output | 1 | Ready, low while extension states remain |

## Verification
The hardest conditions to reach from the pins are stacked extensions and a wait count that is cut short. The first is a hold that gives way to a peripheral cycle, whose wait sampling point then falls at PD2. The second is a continuous wait that reloads the count with zero partway through a long count. Both depend on driving `cwait_n` in exactly the right processor cycle. The bench computes each sampling cycle from the number of hold states and the peripheral flag, and schedules the low run of `cwait_n` and the switch of `wait_n` relative to that cycle. Each scenario is judged by counting the half-cycles in which every output is low, and those counts are compared with closed-form expectations.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_HOLD, ST_T2, ST_TD, ST_TW, ST_T3, ST_T4
  } bus_st_e;
endpackage

// File: rtl/wsc_phase.sv
module wsc_phase (
  input  logic clk,
  input  logic rst_n,
  output logic mid_en,
  output logic step_en,
  output logic first_half
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;

  // edge closing the first half samples mid-state, the other changes state
  assign mid_en     = ~half_q;
  assign step_en    = half_q;
  assign first_half = ~half_q;
endmodule

// File: rtl/wsc_waitcnt.sv
module wsc_waitcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             first,
  input  logic             cwait_n,
  input  logic [CNT_W-1:0] code,
  output logic             go_wait
);
  logic [CNT_W-1:0] cnt_q, eff;

  always_comb begin
    eff     = first ? code : cnt_q;
    go_wait = !cwait_n || (eff != '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (sample_en) begin
      if (!cwait_n)        cnt_q <= code;
      else if (eff != '0)  cnt_q <= eff - 1'b1;
      else                 cnt_q <= '0;
    end
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq import wsc_pkg::*; #(
  parameter int PER_WAITS  = 5,
  parameter int PER_SAMPLE = 2,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mid_en,
  input  logic             step_en,
  input  logic             ads_n,
  input  logic             xfer_wr,
  input  logic             cwait_n,
  input  logic             per_n,
  input  logic             go_wait,
  output bus_st_e          st_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             per_q,
  output logic             wr_q,
  output logic             rdy_q,
  output logic             sample_en,
  output logic             first
);
  localparam logic [IDX_W-1:0] SAMP_I = IDX_W'(PER_SAMPLE);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(PER_WAITS - 1);

  bus_st_e          plan_st, plan_st_q;
  logic [IDX_W-1:0] plan_idx, plan_idx_q;

  always_comb begin
    sample_en = mid_en && ((st_q == ST_T2 && !per_q) ||
                           (st_q == ST_TD && idx_q == SAMP_I) ||
                           (st_q == ST_TW));
    first     = (st_q != ST_TW);
  end

  // successor chosen at mid-state, applied at the next state boundary
  always_comb begin
    plan_st  = st_q;
    plan_idx = idx_q;
    case (st_q)
      ST_T2:
        if (per_q) begin
          plan_st  = ST_TD;
          plan_idx = '0;
        end else begin
          plan_st = go_wait ? ST_TW : ST_T3;
        end
      ST_TD:
        if (idx_q == SAMP_I && go_wait) plan_st = ST_TW;
        else if (idx_q == LAST_I)       plan_st = ST_T3;
        else                            plan_idx = idx_q + 1'b1;
      ST_TW:
        if (!go_wait) begin
          if (per_q) begin
            plan_st  = ST_TD;
            plan_idx = SAMP_I + 1'b1;
          end else begin
            plan_st = ST_T3;
          end
        end
      ST_T3:   plan_st = ST_T4;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      plan_st_q  <= ST_IDLE;
      plan_idx_q <= '0;
      per_q      <= 1'b0;
      wr_q       <= 1'b0;
      rdy_q      <= 1'b1;
    end else if (mid_en) begin
      plan_st_q  <= plan_st;
      plan_idx_q <= plan_idx;
      rdy_q      <= (plan_st inside {ST_IDLE, ST_T1, ST_T3, ST_T4});
    end else if (step_en) begin
      case (st_q)
        ST_IDLE, ST_T4:
          if (!ads_n) begin
            st_q <= ST_T1;
            wr_q <= xfer_wr;
          end else begin
            st_q <= ST_IDLE;
          end
        ST_T1:
          if (!cwait_n) begin
            st_q  <= ST_HOLD;
            rdy_q <= 1'b0;
          end else begin
            st_q  <= ST_T2;
            per_q <= !per_n;
          end
        ST_HOLD:
          if (cwait_n) begin
            st_q  <= ST_T2;
            per_q <= !per_n;
          end
        default: begin
          st_q  <= plan_st_q;
          idx_q <= plan_idx_q;
        end
      endcase
    end
endmodule

// File: rtl/wsc_strobe.sv
module wsc_strobe import wsc_pkg::*; #(
  parameter int PER_WAITS = 5,
  parameter int IDX_W     = 3
) (
  input  bus_st_e          st,
  input  logic [IDX_W-1:0] idx,
  input  logic             first_half,
  input  logic             per_q,
  input  logic             wr_q,
  output logic             rd_n,
  output logic             wr_n,
  output logic             dbe_n,
  output logic             tso_n
);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(PER_WAITS - 1);

  logic active, strb_on, dbe_on;

  always_comb begin
    active = st inside {ST_T2, ST_TD, ST_TW, ST_T3};
    if (per_q) strb_on = (st == ST_TD && idx != LAST_I) || (st == ST_TW);
    else       strb_on = st inside {ST_T2, ST_TW, ST_T3};
    dbe_on = (active && !(st == ST_T2 && first_half && !wr_q)) ||
             (st == ST_T4 && first_half);
    rd_n  = !(strb_on && !wr_q);
    wr_n  = !(strb_on && wr_q);
    dbe_n = !dbe_on;
    tso_n = !active;
  end
endmodule

// File: rtl/wait_state_ctl.sv
module wait_state_ctl import wsc_pkg::*; #(
  parameter int WAIT_W     = 4,
  parameter int PER_WAITS  = 5,
  parameter int PER_SAMPLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              xfer_wr,
  input  logic              cwait_n,
  input  logic              per_n,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              strb_hiz,
  output logic              cpu_clk_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              strb_oe,
  output logic              dbe_n,
  output logic              tso_n,
  output logic              rdy
);
  localparam int IDX_W = (PER_WAITS > 1) ? $clog2(PER_WAITS) : 1;

  logic             mid_en, step_en, first_half;
  logic             go_wait, sample_en, first, per_q, wr_q;
  bus_st_e          st;
  logic [IDX_W-1:0] idx;

  wsc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .mid_en(mid_en), .step_en(step_en),
    .first_half(first_half)
  );

  wsc_waitcnt #(.CNT_W(WAIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .first(first),
    .cwait_n(cwait_n), .code(~wait_n), .go_wait(go_wait)
  );

  wsc_seq #(.PER_WAITS(PER_WAITS), .PER_SAMPLE(PER_SAMPLE), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mid_en(mid_en), .step_en(step_en),
    .ads_n(ads_n), .xfer_wr(xfer_wr), .cwait_n(cwait_n), .per_n(per_n),
    .go_wait(go_wait), .st_q(st), .idx_q(idx), .per_q(per_q), .wr_q(wr_q),
    .rdy_q(rdy), .sample_en(sample_en), .first(first)
  );

  wsc_strobe #(.PER_WAITS(PER_WAITS), .IDX_W(IDX_W)) u_strb (
    .st(st), .idx(idx), .first_half(first_half), .per_q(per_q), .wr_q(wr_q),
    .rd_n(rd_n), .wr_n(wr_n), .dbe_n(dbe_n), .tso_n(tso_n)
  );

  assign cpu_clk_hi = first_half;
  assign strb_oe    = !strb_hiz;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic dbe_n,
  input logic tso_n,
  input logic rdy
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));

  p_strobe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !tso_n);

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && tso_n) |-> (rd_n && wr_n && dbe_n));

  p_read_dbe_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tso_n) && !rd_n) |-> dbe_n);

  p_write_dbe_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tso_n) && !wr_n) |-> !dbe_n);

  p_end_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tso_n) |-> rdy);
endmodule

bind wait_state_ctl wsc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
  .dbe_n(dbe_n), .tso_n(tso_n), .rdy(rdy)
);

// File: tb/wait_state_ctl_test.sv
module wait_state_ctl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ads_n, xfer_wr, cwait_n, per_n, strb_hiz;
  logic [3:0] wait_n;
  logic       cpu_clk_hi, rd_n, wr_n, strb_oe, dbe_n, tso_n, rdy;

  wait_state_ctl uut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .xfer_wr(xfer_wr),
    .cwait_n(cwait_n), .per_n(per_n), .wait_n(wait_n), .strb_hiz(strb_hiz),
    .cpu_clk_hi(cpu_clk_hi), .rd_n(rd_n), .wr_n(wr_n), .strb_oe(strb_oe),
    .dbe_n(dbe_n), .tso_n(tso_n), .rdy(rdy)
  );

  // wr, hold states, peripheral, cwait offset, cwait run, count before, count after, expected waits
  typedef struct packed {
    logic       wr;
    logic [1:0] h;
    logic       per;
    logic [2:0] off;
    logic [1:0] len;
    logic [3:0] ca;
    logic [3:0] cb;
    logic [4:0] w;
  } vec_t;

  localparam int NV  = 10;
  localparam int WIN = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 3'd0, 2'd0, 4'd0,  4'd0,  5'd0},
    '{1'b1, 2'd0, 1'b0, 3'd0, 2'd0, 4'd5,  4'd5,  5'd5},
    '{1'b0, 2'd0, 1'b0, 3'd0, 2'd2, 4'd10, 4'd10, 5'd12},
    '{1'b1, 2'd0, 1'b1, 3'd0, 2'd0, 4'd0,  4'd0,  5'd0},
    '{1'b0, 2'd0, 1'b1, 3'd0, 2'd1, 4'd5,  4'd5,  5'd6},
    '{1'b0, 2'd2, 1'b0, 3'd0, 2'd1, 4'd2,  4'd2,  5'd3},
    '{1'b1, 2'd0, 1'b0, 3'd3, 2'd1, 4'd11, 4'd0,  5'd4},
    '{1'b0, 2'd3, 1'b1, 3'd0, 2'd0, 4'd0,  4'd0,  5'd0},
    '{1'b1, 2'd0, 1'b0, 3'd0, 2'd0, 4'd15, 4'd15, 5'd15},
    '{1'b0, 2'd0, 1'b0, 3'd0, 2'd1, 4'd0,  4'd0,  5'd1}
  };

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (!cpu_clk_hi) @(negedge clk);
  endtask

  task automatic idle_inputs();
    ads_n = 1'b1; xfer_wr = 1'b0; cwait_n = 1'b1; per_n = 1'b1;
    wait_n = 4'hF; strb_hiz = 1'b0;
  endtask

  function automatic string tag_of(vec_t v);
    if (v.h != 0 && v.per) return "R7 stacked";
    if (v.h != 0)          return "R5 hold";
    if (v.len != 0)        return "R9 reload";
    if (v.w != 0)          return "R8 count";
    if (v.per)             return "R6 peripheral";
    return "R1 basic";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset rd_n", rd_n, 1);
    chk("R1 reset wr_n", wr_n, 1);
    chk("R1 reset dbe_n", dbe_n, 1);
    chk("R1 reset tso_n", tso_n, 1);
    chk("R10 reset rdy", rdy, 1);
    rst_n = 1'b1;
    align();

    // R11: strobe float control, combinational
    strb_hiz = 1'b1; #1;
    chk("R11 float", strb_oe, 0);
    strb_hiz = 1'b0; #1;
    chk("R11 drive", strb_oe, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int sp, e, tso_l, rdy_l, rd_l, wr_l, dbe_l, both_l, first_tso;
      int exp_strb;
      v = VECS[i];
      sp = int'(v.h) + 1 + (v.per ? 3 : 0);
      tso_l = 0; rdy_l = 0; rd_l = 0; wr_l = 0; dbe_l = 0; both_l = 0; first_tso = -1;
      for (int c = -1; c < WIN; c++) begin
        ads_n   = (c == -1) ? 1'b0 : 1'b1;
        xfer_wr = (c == -1) ? v.wr : !v.wr;
        cwait_n = !((c >= 0 && c < int'(v.h)) ||
                    (c >= sp + int'(v.off) && c < sp + int'(v.off) + int'(v.len)));
        per_n   = (c == int'(v.h)) ? !v.per : 1'b0;
        wait_n  = (c < sp + int'(v.off)) ? ~v.ca : ~v.cb;
        for (int hf = 0; hf < 2; hf++) begin
          if (hf == 1) @(negedge clk);
          if (!tso_n) begin
            tso_l++;
            if (first_tso < 0) first_tso = c;
          end
          if (!rdy)   rdy_l++;
          if (!rd_n)  rd_l++;
          if (!wr_n)  wr_l++;
          if (!dbe_n) dbe_l++;
          if (!rd_n && !wr_n) both_l++;
        end
        @(negedge clk);
      end
      e        = (v.per ? 5 : 0) + int'(v.w);
      exp_strb = v.per ? 2 * (4 + int'(v.w)) : 2 * (2 + int'(v.w));
      $display("vector %0d", i);
      chk(tag_of(v), tso_l, 2 * (2 + e));
      chk("R3 tso start", first_tso, int'(v.h) + 1);
      chk("R10 rdy low halves", rdy_l, 2 * e + ((v.h != 0) ? 2 * int'(v.h) + 1 : 0));
      chk(v.per ? "R6 strobe width" : "R4 strobe width", v.wr ? wr_l : rd_l, exp_strb);
      chk("R2 other strobe idle", v.wr ? rd_l : wr_l, 0);
      chk("R2 exclusive", both_l, 0);
      chk("R4 dbe halves", dbe_l, 2 * (2 + e) + 1 - (v.wr ? 0 : 1));
    end

    // R1: back-to-back, address strobe low again during T4
    begin
      int tso_l, rd_l, tso_t1b;
      idle_inputs();
      tso_l = 0; rd_l = 0; tso_t1b = 0;
      for (int c = -1; c < 12; c++) begin
        ads_n = (c == -1 || c == 3) ? 1'b0 : 1'b1;
        for (int hf = 0; hf < 2; hf++) begin
          if (hf == 1) @(negedge clk);
          if (!tso_n) tso_l++;
          if (!rd_n)  rd_l++;
          if (c == 4 && hf == 0) tso_t1b = tso_n;
        end
        @(negedge clk);
      end
      chk("R1 back-to-back tso", tso_l, 8);
      chk("R1 back-to-back rd", rd_l, 8);
      chk("R1 second T1 tso high", tso_t1b, 1);
    end

    // R1: idle ignores extension inputs
    begin
      int act;
      idle_inputs();
      act = 0;
      for (int c = 0; c < 10; c++) begin
        cwait_n = c[0];
        per_n   = c[1];
        wait_n  = 4'h0;
        for (int hf = 0; hf < 2; hf++) begin
          if (hf == 1) @(negedge clk);
          if (!tso_n || !rd_n || !wr_n || !dbe_n || !rdy) act++;
        end
        @(negedge clk);
      end
      chk("R1 idle quiet", act, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule